// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the embedded program/erase engine of a byte-wide flash array. It watches single-cycle host writes (20-bit address, 8-bit data), checks them against the unlock handshakes the flash command set requires, and turns a complete, correct sequence into a one-cycle start request toward the engine, with the target address, data byte or list of selected sectors latched beside it. Any cycle that does not fit the expected pattern drops the decoder back to array-read mode, and nothing is started.

Which commands are accepted depends on the current state. While a program or chip erase runs, every write is ignored. A running sector erase accepts only a suspend. While an erase is suspended, the host may program bytes outside the suspended sectors, read identification codes, or resume. In identification mode, a read address returns the manufacturer code, the device code, or the protection flag of any sector. The engine reports completion with a one-cycle done pulse.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `rd_array` is 1, `busy_o`, `susp_o` and `asel_o` are 0, `sect_mask` is all zero and no request pulse is issued.
- R2: Writing AAh at low address 555h, 55h at 2AAh and A0h at 555h, then one write of any address and data, gives exactly one `start_prog` pulse with that address and data on `op_addr` and `op_data`, and raises `busy_o`. The low address is bits 10:0.
- R3: A write whose address or data does not match the next expected cycle ends the sequence. `rd_array` returns to 1 right after it, and the cycles that would have followed start nothing.
- R4: F0h written before the final cycle of a sequence abandons it. While a program or chip erase runs, every write is ignored, including F0h and B0h.
- R5: The six-cycle chip erase (AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, 10h/555h) gives exactly one `start_chip` pulse and raises `busy_o`.
- R6: If the sixth erase cycle is 30h, the sector at address bits 19:13 is set in `sect_mask` and a collection window opens. Each further 30h adds a sector and restarts the window. `start_sect` pulses `WIN_CYC` cycles after the last 30h. Any other write in the window, except B0h, clears the mask and returns to read mode with no start.
- R7: 90h as the third cycle enters identification mode (`asel_o`=1). Read offset (bits 7:0) 00h returns `MFR_ID`, 01h returns `DEV_ID`, 02h returns 01h if the sector is protected and 00h if not, and any other offset returns 00h. Only an F0h write leaves the mode.
- R8: B0h during a running sector erase gives one `susp_req` pulse and sets `susp_o`. During the window it sets `susp_o` without starting the engine. During program or chip erase it is ignored.
- R9: 30h with no sequence pending while suspended clears `susp_o` and raises `busy_o`. It pulses `resume_req` if the erase had started, or `start_sect` if it was suspended in its window. A further 30h during the erase is ignored.
- R10: While suspended, a program aimed at a sector in `sect_mask` is refused. One aimed elsewhere starts, and on completion the decoder is again suspended. Leaving identification mode entered while suspended also returns to the suspended state.
- R11: An `eng_done` pulse ends a running operation and returns to read mode. After a sector erase completes, `sect_mask` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset to read mode |
| wr_en | input | 1 | Host write strobe, one cycle per bus write |
| addr | input | ADDR_W | Host address (write target and read address) |
| wdata | input | 8 | Host write data |
| sect_prot | input | 2**SECT_W | Protection flag per sector |
| eng_done | input | 1 | Engine completion pulse |
| start_prog | output | 1 | Byte program request pulse |
| start_chip | output | 1 | Chip erase request pulse |
| start_sect | output | 1 | Sector erase request pulse |
| susp_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| op_addr | output | ADDR_W | Latched program address |
| op_data | output | 8 | Latched program data |
| sect_mask | output | 2**SECT_W | Sectors selected for erase |
| busy_o | output | 1 | Program or erase running |
| susp_o | output | 1 | Sector erase suspended |
| asel_o | output | 1 | Identification mode active |
| asel_data | output | 8 | Identification code for `addr` |
| rd_array | output | 1 | Read mode with no sequence in progress |

## Verification
The hardest case to reach from the ports is a program issued while an erase is suspended. It needs a full sector erase sequence, an expired window, a suspend, and then a complete four-cycle program, with its target checked against the sectors held in the mask. The stimulus builds this with directed sequences and then tries both a suspended sector and a free one. It repeats the suspend inside the collection window, so that the resume path that must start the engine instead of resuming it is also covered. Random address and data bytes fill the program and garbage-write phases, and random protection vectors fill the identification reads.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 7,
  parameter int WIN_CYC = 64,
  parameter logic [7:0] MFR_ID = 8'h01,
  parameter logic [7:0] DEV_ID = 8'h38
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [7:0]               wdata,
  input  logic [(1<<SECT_W)-1:0]   sect_prot,
  input  logic                     eng_done,
  output logic                     start_prog,
  output logic                     start_chip,
  output logic                     start_sect,
  output logic                     susp_req,
  output logic                     resume_req,
  output logic [ADDR_W-1:0]        op_addr,
  output logic [7:0]               op_data,
  output logic [(1<<SECT_W)-1:0]   sect_mask,
  output logic                     busy_o,
  output logic                     susp_o,
  output logic                     asel_o,
  output logic [7:0]               asel_data,
  output logic                     rd_array
);
  localparam int NSECT = 1 << SECT_W;
  localparam int CW = $clog2(WIN_CYC + 1);

  typedef enum logic [2:0] {M_READ, M_ASEL, M_PROG, M_CHIP, M_WIN, M_SECT} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_U1, S_CMD, S_PDATA, S_EU1, S_EU2, S_ECMD} step_t;

  mode_t mode;
  step_t step;
  logic ers_go;
  logic [CW-1:0] win_cnt;

  wire [SECT_W-1:0] sec = addr[ADDR_W-1 -: SECT_W];
  wire [NSECT-1:0] sec_bit = {{(NSECT-1){1'b0}}, 1'b1} << sec;
  wire at_a = addr[10:0] == 11'h555;
  wire at_b = addr[10:0] == 11'h2AA;
  wire unl1 = at_a && wdata == 8'hAA;
  wire unl2 = at_b && wdata == 8'h55;

  assign busy_o   = mode == M_PROG || mode == M_CHIP || mode == M_SECT;
  assign asel_o   = mode == M_ASEL;
  assign rd_array = mode == M_READ && step == S_IDLE;

  always_comb begin
    asel_data = 8'h00;
    if (asel_o)
      case (addr[7:0])
        8'h00: asel_data = MFR_ID;
        8'h01: asel_data = DEV_ID;
        8'h02: asel_data = {7'b0, sect_prot[sec]};
        default: asel_data = 8'h00;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_READ;
      step <= S_IDLE;
      susp_o <= 1'b0;
      ers_go <= 1'b0;
      win_cnt <= '0;
      sect_mask <= '0;
      op_addr <= '0;
      op_data <= '0;
      start_prog <= 1'b0;
      start_chip <= 1'b0;
      start_sect <= 1'b0;
      susp_req <= 1'b0;
      resume_req <= 1'b0;
    end else begin
      start_prog <= 1'b0;
      start_chip <= 1'b0;
      start_sect <= 1'b0;
      susp_req <= 1'b0;
      resume_req <= 1'b0;
      case (mode)
        M_READ: if (wr_en) begin
          step <= S_IDLE;
          case (step)
            S_IDLE:
              if (unl1) step <= S_U1;
              else if (susp_o && wdata == 8'h30) begin
                susp_o <= 1'b0;
                mode <= M_SECT;
                if (ers_go) resume_req <= 1'b1;
                else begin
                  start_sect <= 1'b1;
                  ers_go <= 1'b1;
                end
              end
            S_U1: if (unl2) step <= S_CMD;
            S_CMD:
              if (at_a && wdata == 8'hA0) step <= S_PDATA;
              else if (at_a && wdata == 8'h90) mode <= M_ASEL;
              else if (at_a && wdata == 8'h80 && !susp_o) step <= S_EU1;
            S_PDATA:
              if (!(susp_o && sect_mask[sec])) begin
                start_prog <= 1'b1;
                op_addr <= addr;
                op_data <= wdata;
                mode <= M_PROG;
              end
            S_EU1: if (unl1) step <= S_EU2;
            S_EU2: if (unl2) step <= S_ECMD;
            S_ECMD:
              if (at_a && wdata == 8'h10) begin
                start_chip <= 1'b1;
                mode <= M_CHIP;
              end else if (wdata == 8'h30) begin
                sect_mask <= sec_bit;
                win_cnt <= CW'(WIN_CYC - 1);
                ers_go <= 1'b0;
                mode <= M_WIN;
              end
            default: step <= S_IDLE;
          endcase
        end
        M_ASEL: if (wr_en && wdata == 8'hF0) mode <= M_READ;
        M_PROG, M_CHIP: if (eng_done) mode <= M_READ;
        M_WIN:
          if (wr_en) begin
            if (wdata == 8'h30) begin
              sect_mask <= sect_mask | sec_bit;
              win_cnt <= CW'(WIN_CYC - 1);
            end else if (wdata == 8'hB0) begin
              susp_o <= 1'b1;
              mode <= M_READ;
            end else begin
              sect_mask <= '0;
              mode <= M_READ;
            end
          end else if (win_cnt == '0) begin
            start_sect <= 1'b1;
            ers_go <= 1'b1;
            mode <= M_SECT;
          end else win_cnt <= win_cnt - 1'b1;
        M_SECT:
          if (eng_done) begin
            sect_mask <= '0;
            ers_go <= 1'b0;
            mode <= M_READ;
          end else if (wr_en && wdata == 8'hB0) begin
            susp_req <= 1'b1;
            susp_o <= 1'b1;
            mode <= M_READ;
          end
        default: mode <= M_READ;
      endcase
    end
  end
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int NSECT = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [7:0]       wdata,
  input logic             start_prog,
  input logic             start_chip,
  input logic             start_sect,
  input logic             susp_req,
  input logic             resume_req,
  input logic             busy_o,
  input logic             susp_o,
  input logic             asel_o,
  input logic [NSECT-1:0] sect_mask
);
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_prog, start_chip, start_sect, susp_req, resume_req})); // R2
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_chip) |-> !$past(busy_o)); // R4
  AST_SUSP_FROM_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    susp_req |-> $past(busy_o && !susp_o) && susp_o && !busy_o); // R8
  AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> $past(susp_o) && busy_o && !susp_o); // R9
  AST_ASEL_EXIT_F0: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asel_o) |-> $past(wr_en && wdata == 8'hF0)); // R7
  AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(sect_mask)); // R6
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata),
  .start_prog(start_prog), .start_chip(start_chip), .start_sect(start_sect),
  .susp_req(susp_req), .resume_req(resume_req), .busy_o(busy_o),
  .susp_o(susp_o), .asel_o(asel_o), .sect_mask(sect_mask)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int WIN = 64;
  logic clk = 0, rst_n = 0, wr_en = 0, eng_done = 0;
  logic [19:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [127:0] sect_prot = 0;
  logic start_prog, start_chip, start_sect, susp_req, resume_req;
  logic [19:0] op_addr;
  logic [7:0] op_data, asel_data;
  logic [127:0] sect_mask;
  logic busy_o, susp_o, asel_o, rd_array;
  int checks = 0, errors = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0, n_susp = 0, n_res = 0;

  flash_cmd_decoder #(.WIN_CYC(WIN)) uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (start_prog) n_prog++;
    if (start_chip) n_chip++;
    if (start_sect) n_sect++;
    if (susp_req) n_susp++;
    if (resume_req) n_res++;
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  task automatic unlock();
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55);
  endtask

  task automatic prog(logic [19:0] a, logic [7:0] d);
    unlock(); wr(20'h00555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    unlock(); wr(20'h00555, 8'h80); unlock();
  endtask

  function automatic logic [19:0] sa(int n);
    return {n[6:0], 13'h0ABC};
  endfunction

  function automatic logic [7:0] exp_id(logic [19:0] a, logic [127:0] p);
    case (a[7:0])
      8'h00: return 8'h01;
      8'h01: return 8'h38;
      8'h02: return {7'b0, p[a[19:13]]};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [127:0] bitm(int n);
    return 128'd1 << n;
  endfunction

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k, p0;
    logic [19:0] a;
    logic [7:0] d;
    void'($urandom(32'h5eed1234));
    idle(3);
    chk("R1 rd_array", rd_array, 1); chk("R1 busy", busy_o, 0);
    chk("R1 mask", sect_mask, 0); chk("R1 asel", asel_o, 0); chk("R1 susp", susp_o, 0);
    rst_n = 1; idle(2);
    chk("R1 no pulses", n_prog + n_chip + n_sect + n_susp + n_res, 0);

    // R2 directed program then R4 writes ignored while busy
    prog(20'hA1234, 8'h5C); idle(1);
    chk("R2 count", n_prog, 1); chk("R2 addr", op_addr, 20'hA1234);
    chk("R2 data", op_data, 8'h5C); chk("R2 busy", busy_o, 1);
    wr(20'h0, 8'hF0); wr(20'h0, 8'hB0); prog(20'h1, 8'h1); idle(1);
    chk("R4 busy kept", busy_o, 1); chk("R4 no new prog", n_prog, 1);
    chk("R8 no susp in prog", n_susp, 0);
    done_pulse();
    chk("R11 idle after done", busy_o, 0); chk("R11 rd_array", rd_array, 1);

    // R2 random programs
    for (int i = 0; i < 20; i++) begin
      a = 20'($urandom); d = 8'($urandom);
      p0 = n_prog;
      prog(a, d); idle(1);
      chk("R2 rnd count", n_prog, p0 + 1);
      chk("R2 rnd addr", op_addr, a); chk("R2 rnd data", op_data, d);
      done_pulse();
    end

    // R3 wrong cycles
    wr(20'h00555, 8'hAA);
    chk("R3 seq open", rd_array, 0);
    wr(20'h002AA, 8'h56);
    chk("R3 bad data back", rd_array, 1);
    wr(20'h00555, 8'hA0); wr(20'h00100, 8'h11);
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55);
    chk("R3 bad addr back", rd_array, 1);
    wr(20'h00555, 8'hA0); wr(20'h00100, 8'h11); idle(1);
    chk("R3 no start", n_prog, 21); chk("R3 not busy", busy_o, 0);
    for (int i = 0; i < 100; i++) begin
      d = 8'($urandom);
      if (d == 8'hAA) d = 8'h00;
      wr(20'($urandom), d);
    end
    idle(1);
    chk("R3 garbage no start", n_prog + n_chip + n_sect + n_susp + n_res, 21);
    chk("R3 garbage read", rd_array, 1);

    // R4 reset mid sequence
    unlock(); wr(20'h0, 8'hF0);
    chk("R4 abort read", rd_array, 1);
    wr(20'h00555, 8'hA0); wr(20'h00200, 8'h22); idle(1);
    chk("R4 abort no prog", n_prog, 21);

    // R5 chip erase, R8 suspend ignored
    erase_pre(); wr(20'h00555, 8'h10); idle(1);
    chk("R5 chip start", n_chip, 1); chk("R5 busy", busy_o, 1);
    wr(20'h0, 8'hB0); idle(1);
    chk("R8 chip no susp", n_susp, 0); chk("R8 chip susp_o", susp_o, 0);
    done_pulse();
    chk("R11 chip done", busy_o, 0);

    // R6 sector erase with two sectors
    erase_pre(); wr(sa(5), 8'h30);
    chk("R6 mask first", sect_mask, bitm(5));
    idle(10); wr(sa(9), 8'h30);
    k = 0;
    while (!start_sect && k < 500) begin @(negedge clk); k++; end
    chk("R6 window length", k, WIN);
    chk("R6 mask both", sect_mask, bitm(5) | bitm(9));
    idle(1);
    chk("R6 start count", n_sect, 1); chk("R6 busy", busy_o, 1);
    wr(20'h0, 8'hB0); idle(1);
    chk("R8 susp pulse", n_susp, 1); chk("R8 susp_o", susp_o, 1);
    chk("R8 not busy", busy_o, 0);
    prog(sa(5) | 20'h7, 8'h44); idle(1);
    chk("R10 refused in suspended sector", n_prog, 21);
    prog(sa(3), 8'h66); idle(1);
    chk("R10 prog elsewhere", n_prog, 22); chk("R10 prog busy", busy_o, 1);
    done_pulse();
    chk("R10 back suspended", susp_o, 1); chk("R10 idle", busy_o, 0);
    unlock(); wr(20'h00555, 8'h90);
    chk("R10 asel in susp", asel_o, 1);
    wr(20'h0, 8'hF0);
    chk("R10 asel exit", asel_o, 0); chk("R10 still susp", susp_o, 1);
    wr(20'h0, 8'h30); idle(1);
    chk("R9 resume pulse", n_res, 1); chk("R9 busy", busy_o, 1);
    chk("R9 susp clear", susp_o, 0);
    wr(20'h0, 8'h30); idle(1);
    chk("R9 second resume ignored", n_res, 1);
    wr(20'h0, 8'hB0); idle(1);
    chk("R8 resuspend", n_susp, 2);
    wr(20'h0, 8'h30); idle(1);
    chk("R9 resume again", n_res, 2);
    done_pulse();
    chk("R11 mask cleared", sect_mask, 0); chk("R11 read", rd_array, 1);

    // R6 window aborted by other write
    erase_pre(); wr(sa(7), 8'h30); wr(20'h0, 8'h55);
    chk("R6 abort read", rd_array, 1); chk("R6 abort mask", sect_mask, 0);
    idle(WIN + 5);
    chk("R6 abort no start", n_sect, 1);

    // R8/R9 suspend inside window
    erase_pre(); wr(sa(2), 8'h30); wr(20'h0, 8'hB0);
    chk("R8 window susp", susp_o, 1);
    idle(WIN + 5);
    chk("R8 window no start", n_sect, 1); chk("R8 window no pulse", n_susp, 2);
    wr(20'h0, 8'h30); idle(1);
    chk("R9 window resume starts", n_sect, 2);
    chk("R9 window resume no resume pulse", n_res, 2);
    done_pulse();

    // R7 identification mode
    sect_prot = {32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
    unlock(); wr(20'h00555, 8'h90);
    chk("R7 enter", asel_o, 1);
    for (int i = 0; i < 40; i++) begin
      a = 20'($urandom);
      if (i % 4 != 3) a[7:0] = 8'(i % 4);
      @(negedge clk); addr = a; #1;
      chk("R7 code", asel_data, exp_id(a, sect_prot));
    end
    unlock(); wr(20'h00555, 8'hA0); wr(20'h0, 8'h12); idle(1);
    chk("R7 stays", asel_o, 1); chk("R7 no prog", n_prog, 22);
    wr(20'h0, 8'hF0);
    chk("R7 exit", asel_o, 0); chk("R7 read", rd_array, 1);

    // R1 reset during operation
    prog(20'h12345, 8'h01); rst_n = 0; idle(2);
    chk("R1 reset busy", busy_o, 0); chk("R1 reset read", rd_array, 1);
    rst_n = 1; idle(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule